// File: doc/BRIEF.md
# Serial Addressed Quad DAC Loader

This block is the digital front end of a four-channel, 14-bit digital-to-analog converter. A host writes one channel at a time over a three-wire serial link made of an active-low frame strobe, a serial clock and a data line. Every frame carries 24 bits: a 5-bit package address, a reserved bit, a 2-bit channel select and a 16-bit data field. Several converters can share one bus. Each converter compares the package address in the frame against its own five strap pins. A broadcast pin makes the converter skip that comparison while still obeying the channel select, so the same channel in every package can be written at once.

Written data first lands in a per-channel input register. A level-sensitive, active-low load line moves all four input registers into the four converter latches together. An asynchronous active-low clear line makes every output report that it is clamped to the sense-ground level. While clear is low, load requests are ignored. After clear is released, the clamp stays in force until the next time load is low.

The serial and load lines are brought into the system clock domain through synchronisers. All edge detection happens in that domain.

Top module: `quad_dac_serial_loader`

## Requirements
- R1: A synchronous reset zeroes all four input registers and all four converter latches, and sets every clamp flag to 1.
- R2: While the frame strobe is low, one data bit is taken on each falling serial-clock edge, most significant bit first. In the 24-bit word, bits 23..19 are the package address, bit 18 is reserved, bits 17..16 select the channel (0 to 3), and bits 13..0 are the 14-bit code. Bits 15..14 are ignored.
- R3: A frame that holds any number of falling serial-clock edges other than 24 between the strobe falling and rising writes no input register.
- R4: With the broadcast pin low, a frame whose package address differs from the strap pins writes no input register.
- R5: With the broadcast pin high, a frame is written whatever its package address, and only into the channel that the frame selects.
- R6: While the load line is high, a written frame leaves every converter latch output unchanged.
- R7: While the synchronised load line is low and clear is high, every latch takes its input-register value each clock, and all clamp flags drop to 0.
- R8: While clear is low, every clamp flag is 1 without waiting for a clock, and the load line changes no latch.
- R9: After clear returns high, the clamp flags stay at 1 until the load line is next seen low.
- R10: A frame whose strobe rises at synchronised clock k updates its input register at clock k+1. A load line that is low at synchronised clock k updates the latches at clock k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_in | input | 1 | Serial clock, asynchronous, idles high |
| fsync_n_in | input | 1 | Frame strobe, active low |
| sdata_in | input | 1 | Serial data |
| load_n_in | input | 1 | Latch load, active low, level sensitive |
| clear_n | input | 1 | Asynchronous clamp to sense ground, active low |
| pkg_strap | input | PKG_W | Package address of this converter |
| pkg_ignore | input | 1 | Broadcast: skip the package address comparison |
| dac_code | output | CH_N*CODE_W | Latch values, channel n at bits [n*CODE_W +: CODE_W] |
| clamp_flag | output | CH_N | Per-output flag: 1 means forced to sense ground |

## Verification
Two things can happen in the same cycle: a frame commits into an input register, and a load held low copies the input registers into the latches. The bench holds load low across a whole frame. The reference model then expects each latch to show the old register value on the commit clock and the new value one clock later. The second pairing is clear with load. Load is pulsed while clear is low, and clear is released while load is still low. A model updated every clock judges the exact cycle in which each latch changes and each clamp flag is released.

// File: rtl/qdl_pkg.sv
package qdl_pkg;
  localparam int unsigned DATA_FIELD_W = 16;
  localparam int unsigned RSV_W        = 1;

  function automatic int unsigned frame_width(input int unsigned pkg_w, input int unsigned ch_aw);
    return pkg_w + RSV_W + ch_aw + DATA_FIELD_W;
  endfunction

  typedef enum logic {SH_IDLE = 1'b0, SH_CAPTURE = 1'b1} sh_state_e;
endpackage

// File: rtl/qdl_sync.sv
module qdl_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= {STAGES{RST_VAL}};
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/qdl_shifter.sv
module qdl_shifter #(
  parameter int unsigned FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s,
  input  logic               fsync_n_s,
  input  logic               sdata_s,
  output logic               frame_vld,
  output logic [FRAME_W-1:0] frame_word
);
  import qdl_pkg::*;
  localparam int unsigned CNT_MAX = FRAME_W + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  sh_state_e          state;
  logic               sclk_d, fsync_d;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] shreg;
  logic               strobe_fall, strobe_rise, clk_fall;

  assign strobe_fall = fsync_d & ~fsync_n_s;
  assign strobe_rise = ~fsync_d & fsync_n_s;
  assign clk_fall    = sclk_d & ~sclk_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SH_IDLE;
      sclk_d     <= 1'b1;
      fsync_d    <= 1'b1;
      bit_cnt    <= '0;
      shreg      <= '0;
      frame_vld  <= 1'b0;
      frame_word <= '0;
    end else begin
      sclk_d    <= sclk_s;
      fsync_d   <= fsync_n_s;
      frame_vld <= 1'b0;
      if (strobe_fall) begin
        state   <= SH_CAPTURE;
        bit_cnt <= '0;
      end else if (strobe_rise) begin
        state <= SH_IDLE;
        if (state == SH_CAPTURE && bit_cnt == CNT_W'(FRAME_W)) begin
          frame_vld  <= 1'b1;
          frame_word <= shreg;
        end
      end else if (state == SH_CAPTURE && !fsync_n_s && clk_fall) begin
        shreg <= {shreg[FRAME_W-2:0], sdata_s};
        if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/qdl_channel.sv
module qdl_channel #(
  parameter int unsigned CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              xfer,
  output logic [CODE_W-1:0] inreg_q,
  output logic [CODE_W-1:0] latch_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      inreg_q <= '0;
      latch_q <= '0;
    end else begin
      if (wr_en) inreg_q <= wr_code;
      if (xfer)  latch_q <= inreg_q;
    end
  end
endmodule

// File: rtl/quad_dac_serial_loader.sv
module quad_dac_serial_loader #(
  parameter int unsigned CH_N        = 4,
  parameter int unsigned CODE_W      = 14,
  parameter int unsigned PKG_W       = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sclk_in,
  input  logic                     fsync_n_in,
  input  logic                     sdata_in,
  input  logic                     load_n_in,
  input  logic                     clear_n,
  input  logic [PKG_W-1:0]         pkg_strap,
  input  logic                     pkg_ignore,
  output logic [CH_N*CODE_W-1:0]   dac_code,
  output logic [CH_N-1:0]          clamp_flag
);
  localparam int unsigned CH_AW   = $clog2(CH_N);
  localparam int unsigned FRAME_W = qdl_pkg::frame_width(PKG_W, CH_AW);
  localparam int unsigned CH_LSB  = qdl_pkg::DATA_FIELD_W;
  localparam int unsigned PKG_LSB = FRAME_W - PKG_W;

  logic [3:0]               sync_q;
  logic                     sclk_s, fsync_n_s, sdata_s, load_req;
  logic                     frame_vld;
  logic [FRAME_W-1:0]       frame_word;
  logic                     accept, xfer;
  logic [CH_AW-1:0]         sel_ch;
  logic [CH_N*CODE_W-1:0]   inreg_flat;

  // bit 3 sclk, 2 strobe, 1 data, 0 load; idle levels 1,1,0,1
  qdl_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1101)) u_sync (
    .clk(clk), .rst(rst),
    .d({sclk_in, fsync_n_in, sdata_in, load_n_in}),
    .q(sync_q)
  );
  assign sclk_s    = sync_q[3];
  assign fsync_n_s = sync_q[2];
  assign sdata_s   = sync_q[1];
  assign load_req  = ~sync_q[0];

  qdl_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst),
    .sclk_s(sclk_s), .fsync_n_s(fsync_n_s), .sdata_s(sdata_s),
    .frame_vld(frame_vld), .frame_word(frame_word)
  );

  assign sel_ch = frame_word[CH_LSB +: CH_AW];
  assign accept = frame_vld & (pkg_ignore | (frame_word[PKG_LSB +: PKG_W] == pkg_strap));
  assign xfer   = load_req & clear_n;

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    qdl_channel #(.CODE_W(CODE_W)) u_chan (
      .clk(clk), .rst(rst),
      .wr_en(accept && sel_ch == CH_AW'(ch)),
      .wr_code(frame_word[CODE_W-1:0]),
      .xfer(xfer),
      .inreg_q(inreg_flat[ch*CODE_W +: CODE_W]),
      .latch_q(dac_code[ch*CODE_W +: CODE_W])
    );
  end

  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n)  clamp_flag <= '1;
    else if (rst)  clamp_flag <= '1;
    else if (xfer) clamp_flag <= '0;
  end
endmodule

// File: rtl/qdl_checker.sv
module qdl_checker #(
  parameter int unsigned CH_N   = 4,
  parameter int unsigned CODE_W = 14
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   clear_n,
  input logic                   load_req,
  input logic                   frame_vld,
  input logic [CH_N*CODE_W-1:0] inreg_flat,
  input logic [CH_N*CODE_W-1:0] latch_flat,
  input logic [CH_N-1:0]        flags
);
  assert_clear_forces_flags_R8: assert property (@(posedge clk)
    !clear_n |-> (flags == '1));

  assert_clear_freezes_latch_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(clear_n) && !$past(rst)) |-> $stable(latch_flat));

  assert_load_high_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(load_req) && !$past(rst)) |-> $stable(latch_flat));

  assert_load_low_copies_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(load_req) && $past(clear_n) && !$past(rst)) |-> (latch_flat == $past(inreg_flat)));

  assert_release_needs_load_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(flags) != '0 && flags == '0) |-> $past(load_req));

  assert_write_needs_frame_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(frame_vld) && !$past(rst)) |-> $stable(inreg_flat));
endmodule

bind quad_dac_serial_loader qdl_checker #(.CH_N(CH_N), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .clear_n(clear_n), .load_req(load_req),
  .frame_vld(frame_vld), .inreg_flat(inreg_flat),
  .latch_flat(dac_code), .flags(clamp_flag)
);

// File: tb/quad_dac_serial_loader_bench.sv
`timescale 1ns/1ps
module quad_dac_serial_loader_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b1, fsync_n = 1'b1, sdata = 1'b0, load_n = 1'b1, clear_n = 1'b1;
  logic [4:0] strap = 5'h16;
  logic pkg_ign = 1'b0;
  logic [55:0] dac_code;
  logic [3:0]  clamp_flag;

  int vectors = 0, miscompares = 0, cycles = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  quad_dac_serial_loader u_quad_dac_serial_loader (
    .clk(clk), .rst(rst), .sclk_in(sclk), .fsync_n_in(fsync_n), .sdata_in(sdata),
    .load_n_in(load_n), .clear_n(clear_n), .pkg_strap(strap), .pkg_ignore(pkg_ign),
    .dac_code(dac_code), .clamp_flag(clamp_flag)
  );

  // reference model: input delay queues, integer counters
  logic [1:0] q_sc, q_fs, q_sd, q_ld;
  logic p_sc, p_fs;
  bit   m_act, m_vld;
  int   m_cnt;
  logic [23:0] m_sh, m_word;
  logic [13:0] m_in [4];
  logic [13:0] m_lat [4];
  logic [3:0]  m_flag;

  always @(posedge clk) begin
    if (rst) begin
      q_sc = 2'b11; q_fs = 2'b11; q_sd = 2'b00; q_ld = 2'b11;
      p_sc = 1; p_fs = 1; m_act = 0; m_vld = 0; m_cnt = 0; m_sh = '0; m_word = '0;
      for (int i = 0; i < 4; i++) begin m_in[i] = '0; m_lat[i] = '0; end
      m_flag = 4'hF;
    end else begin
      bit go, nv;
      go = !q_ld[1] && clear_n;
      if (go) for (int i = 0; i < 4; i++) m_lat[i] = m_in[i];
      if (!clear_n) m_flag = 4'hF; else if (go) m_flag = 4'h0;
      if (m_vld && (pkg_ign || m_word[23:19] == strap)) m_in[m_word[17:16]] = m_word[13:0];
      nv = 0;
      if (p_fs && !q_fs[1]) begin m_act = 1; m_cnt = 0; end
      else if (!p_fs && q_fs[1]) begin
        if (m_act && m_cnt == 24) begin nv = 1; m_word = m_sh; end
        m_act = 0;
      end else if (m_act && !q_fs[1] && p_sc && !q_sc[1]) begin
        m_sh = {m_sh[22:0], q_sd[1]};
        if (m_cnt < 25) m_cnt++;
      end
      m_vld = nv;
      p_sc = q_sc[1]; p_fs = q_fs[1];
      q_sc = {q_sc[0], sclk}; q_fs = {q_fs[0], fsync_n};
      q_sd = {q_sd[0], sdata}; q_ld = {q_ld[0], load_n};
    end
  end

  // compare every clock, shortly after the edge
  always @(posedge clk) begin
    #1;
    cycles++;
    vectors++;
    for (int i = 0; i < 4; i++) begin
      if (dac_code[i*14 +: 14] !== m_lat[i]) begin
        miscompares++;
        $display("FAIL %s ch%0d dac_code actual=%h expected=%h", cur_req, i, dac_code[i*14 +: 14], m_lat[i]);
      end
    end
    if (clamp_flag !== (clear_n ? m_flag : 4'hF)) begin
      miscompares++;
      $display("FAIL %s clamp_flag actual=%b expected=%b", cur_req, clamp_flag, clear_n ? m_flag : 4'hF);
    end
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [23:0] mk(input logic [4:0] p, input logic [1:0] ch, input logic [15:0] d);
    return {p, 1'b0, ch, d};
  endfunction

  task automatic send(input logic [23:0] w, input int nbits);
    fsync_n = 1'b0; wait_n(4);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1; sdata = (i < 24) ? w[23-i] : 1'b0; wait_n(4);
      sclk = 1'b0; wait_n(4);
    end
    sclk = 1'b1; wait_n(4);
    fsync_n = 1'b1; wait_n(6);
  endtask

  task automatic load_pulse();
    load_n = 1'b0; wait_n(5);
    load_n = 1'b1; wait_n(5);
  endtask

  initial begin
    wait_n(5);
    cur_req = "R1"; rst = 1'b0; wait_n(4);
    cur_req = "R6";                       // writes with load high leave latches alone
    send(mk(5'h16, 2'd1, 16'h1ABC), 24);
    send(mk(5'h16, 2'd3, 16'h3FFF), 24);
    wait_n(8);
    cur_req = "R7"; load_pulse();         // ch1=1ABC ch3=3FFF, flags drop
    cur_req = "R4";                       // foreign package, broadcast off
    send(mk(5'h05, 2'd1, 16'h0123), 24); load_pulse();
    cur_req = "R5"; pkg_ign = 1'b1;       // broadcast on: foreign package to ch2
    send(mk(5'h09, 2'd2, 16'h2222), 24); load_pulse();
    pkg_ign = 1'b0;
    cur_req = "R3";                       // short and long frames dropped
    send(mk(5'h16, 2'd0, 16'h1111), 23);
    send(mk(5'h16, 2'd0, 16'h1111), 25);
    load_pulse();
    cur_req = "R2";                       // bits 15..14 ignored, code 0155 to ch0
    send(mk(5'h16, 2'd0, 16'hC155), 24); load_pulse();
    cur_req = "R8"; clear_n = 1'b0; wait_n(4);
    send(mk(5'h16, 2'd1, 16'h0777), 24);
    load_pulse();
    cur_req = "R9"; clear_n = 1'b1; wait_n(10);
    load_pulse();                         // releases flags, ch1 -> 0777
    cur_req = "R10"; load_n = 1'b0;       // commit while load held low
    send(mk(5'h16, 2'd2, 16'h1357), 24);
    wait_n(4);
    cur_req = "R8"; clear_n = 1'b0; wait_n(4);
    send(mk(5'h16, 2'd3, 16'h0042), 24);
    cur_req = "R9"; clear_n = 1'b1; wait_n(6);  // load still low: release at once
    load_n = 1'b1; wait_n(6);
    cur_req = "R1"; rst = 1'b1; wait_n(3); rst = 1'b0; wait_n(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule